// File: doc/BRIEF.md
# Floating-Point Register Rename Map with Load-Only Allocation

This block translates the 32 architectural floating-point register names into tags for a shared pool of 40 physical registers. One decoded instruction is presented per cycle. Each of its two source names is looked up in a map table, and the current physical tag is returned. Its destination is then handled in one of two ways, depending on the kind of instruction.

A floating-point load takes a fresh tag from a pool of unassigned tags and re-points its destination name at that tag. The tag it displaced is returned so that it can be recycled once all older readers are done with it. An arithmetic instruction executes in order, so it takes no fresh tag: it writes through whatever tag the map already holds.

A remapping is permanent until a later load re-points the same name. Any physical tag can serve as the home of a name or as a pending rename. Tags come back into the unassigned pool through a release port. The pool is a circular first-in first-out queue, and it flags an overflow or underflow.

Top module: `fp_rename_map`

## Requirements
- R1: After reset, a source lookup of logical register i returns physical tag i, for every i in 0..31.
- R2: After reset, the unassigned pool holds tags 32 to 39, and successive loads receive them in ascending order.
- R3: An accepted load with destination d sets out_alloc=1 and out_dst_tag to the next pooled tag. It sets out_prev_tag to the tag d held before, and every later lookup of d returns the new tag.
- R4: An accepted instruction with in_wr_dst=1 and in_is_load=0 sets out_alloc=0, and sets both out_dst_tag and out_prev_tag to the tag currently mapped to its destination. The map is left unchanged.
- R5: When a load's source and destination name the same register, the source tag returned is the tag held before the load.
- R6: While the pool is empty, in_ready is 0 whenever in_is_load=1, and the load produces no output. Instructions that are not loads keep in_ready=1 and are renamed normally.
- R7: Released tags join the tail of the pool and are handed out after the tags already in it, in release order.
- R8: A tag released in the same cycle that a load is presented cannot satisfy that cycle's allocation. It is available to an allocation in the following cycle.
- R9: A release while the pool holds 8 tags and no load is accepted is dropped. err_overflow pulses high for exactly one cycle, and the pool contents are unchanged.
- R10: out_valid is high in exactly the cycle after each accepted instruction (in_valid and in_ready at the clock edge), and low otherwise. err_underflow never rises.
- R11: A remapping persists: an arithmetic write or a read of a register reloaded earlier uses the load's tag, with no return to the old home tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_ready | output | 1 | Rename stage can accept the presented instruction |
| in_is_load | input | 1 | Instruction is a floating-point load (always writes its destination) |
| in_wr_dst | input | 1 | Non-load instruction writes its destination |
| in_dst | input | 5 | Destination logical register |
| in_src_a | input | 5 | First source logical register |
| in_src_b | input | 5 | Second source logical register |
| rel_valid | input | 1 | A physical tag is returned to the pool |
| rel_tag | input | 6 | Tag being returned |
| out_valid | output | 1 | Rename results below are valid |
| out_src_a_tag | output | 6 | Physical tag for first source |
| out_src_b_tag | output | 6 | Physical tag for second source |
| out_dst_tag | output | 6 | Physical tag the destination is written to |
| out_prev_tag | output | 6 | Tag the destination was mapped to before this instruction |
| out_alloc | output | 1 | A new tag was taken for the destination |
| err_overflow | output | 1 | One-cycle pulse: a release found the pool full |
| err_underflow | output | 1 | One-cycle pulse: a pop was attempted on an empty pool |

## Verification
The hardest cases need an empty pool, and reaching it takes eight back-to-back loads from reset. The stimulus therefore first drains the pool, and then checks the stall and the non-load bypass.

The same-cycle case also starts from the drained pool. A release is asserted together with a held load, which must stall for one cycle and then receive exactly the released tag.

Overflow is reached without any loads, because the pool starts full. A single release right after reset produces it. A full drain afterwards shows that the dropped tag never entered the pool.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  localparam int FPR_NUM_LOG  = 32;
  localparam int FPR_NUM_PHYS = 40;

  typedef enum logic [1:0] {
    FPR_OP_READ  = 2'd0,
    FPR_OP_WRITE = 2'd1,
    FPR_OP_LOAD  = 2'd2
  } fpr_op_e;

endpackage

// File: rtl/fpr_map_table.sv
module fpr_map_table #(
  parameter int NUM_LOG = 32,
  parameter int TAG_W   = 6,
  localparam int LOG_W  = $clog2(NUM_LOG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LOG_W-1:0] rd_a_idx,
  input  logic [LOG_W-1:0] rd_b_idx,
  input  logic [LOG_W-1:0] rd_d_idx,
  output logic [TAG_W-1:0] rd_a_tag,
  output logic [TAG_W-1:0] rd_b_tag,
  output logic [TAG_W-1:0] rd_d_tag,
  input  logic             wr_en,
  input  logic [LOG_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);

  logic [TAG_W-1:0] tbl [NUM_LOG];

  // Reads see the table before this cycle's write lands.
  assign rd_a_tag = tbl[rd_a_idx];
  assign rd_b_tag = tbl[rd_b_idx];
  assign rd_d_tag = tbl[rd_d_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LOG; i++) begin
        tbl[i] <= TAG_W'(i);
      end
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_tag;
    end
  end

endmodule

// File: rtl/fpr_free_fifo.sv
module fpr_free_fifo #(
  parameter int DEPTH   = 8,
  parameter int TAG_W   = 6,
  parameter int BASE    = 32,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  output logic [TAG_W-1:0] head_tag,
  output logic             empty,
  output logic             err_over,
  output logic             err_under
);

  logic [TAG_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic             full;
  logic             do_pop, do_push;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (count_q == '0);
  assign full     = (count_q == CNT_W'(DEPTH));
  assign head_tag = slot[head_q];
  assign do_pop   = pop && !empty;
  // A push into a full queue is legal only when a pop frees a slot.
  assign do_push  = push && (!full || do_pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        slot[i] <= TAG_W'(BASE + i);
      end
    end else if (do_push) begin
      slot[tail_q] <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q    <= '0;
      tail_q    <= '0;
      count_q   <= CNT_W'(DEPTH);
      err_over  <= 1'b0;
      err_under <= 1'b0;
    end else begin
      if (do_pop)  head_q <= nxt(head_q);
      if (do_push) tail_q <= nxt(tail_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      err_over  <= push && full && !do_pop;
      err_under <= pop && empty;
    end
  end

endmodule

// File: rtl/fpr_out_stage.sv
module fpr_out_stage #(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [TAG_W-1:0] src_a_tag,
  input  logic [TAG_W-1:0] src_b_tag,
  input  logic [TAG_W-1:0] dst_tag,
  input  logic [TAG_W-1:0] prev_tag,
  input  logic             alloc,
  output logic             q_valid,
  output logic [TAG_W-1:0] q_src_a_tag,
  output logic [TAG_W-1:0] q_src_b_tag,
  output logic [TAG_W-1:0] q_dst_tag,
  output logic [TAG_W-1:0] q_prev_tag,
  output logic             q_alloc
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid     <= 1'b0;
      q_src_a_tag <= '0;
      q_src_b_tag <= '0;
      q_dst_tag   <= '0;
      q_prev_tag  <= '0;
      q_alloc     <= 1'b0;
    end else begin
      q_valid <= take;
      if (take) begin
        q_src_a_tag <= src_a_tag;
        q_src_b_tag <= src_b_tag;
        q_dst_tag   <= dst_tag;
        q_prev_tag  <= prev_tag;
        q_alloc     <= alloc;
      end
    end
  end

endmodule

// File: rtl/fp_rename_map.sv
module fp_rename_map
  import fpr_pkg::*;
#(
  parameter int NUM_LOG  = FPR_NUM_LOG,
  parameter int NUM_PHYS = FPR_NUM_PHYS,
  localparam int LOG_W   = $clog2(NUM_LOG),
  localparam int TAG_W   = $clog2(NUM_PHYS),
  localparam int POOL_N  = NUM_PHYS - NUM_LOG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_is_load,
  input  logic             in_wr_dst,
  input  logic [LOG_W-1:0] in_dst,
  input  logic [LOG_W-1:0] in_src_a,
  input  logic [LOG_W-1:0] in_src_b,
  input  logic             rel_valid,
  input  logic [TAG_W-1:0] rel_tag,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_src_a_tag,
  output logic [TAG_W-1:0] out_src_b_tag,
  output logic [TAG_W-1:0] out_dst_tag,
  output logic [TAG_W-1:0] out_prev_tag,
  output logic             out_alloc,
  output logic             err_overflow,
  output logic             err_underflow
);

  fpr_op_e          op;
  logic             accept, take_tag, pool_empty;
  logic [TAG_W-1:0] tag_a, tag_b, tag_d, head_tag, dst_sel;

  always_comb begin
    if (in_is_load)     op = FPR_OP_LOAD;
    else if (in_wr_dst) op = FPR_OP_WRITE;
    else                op = FPR_OP_READ;
  end

  assign in_ready = !(op == FPR_OP_LOAD && pool_empty);
  assign accept   = in_valid && in_ready;
  assign take_tag = accept && (op == FPR_OP_LOAD);
  assign dst_sel  = (op == FPR_OP_LOAD) ? head_tag : tag_d;

  fpr_map_table #(.NUM_LOG(NUM_LOG), .TAG_W(TAG_W)) i_map (
    .clk      (clk),
    .rst      (rst),
    .rd_a_idx (in_src_a),
    .rd_b_idx (in_src_b),
    .rd_d_idx (in_dst),
    .rd_a_tag (tag_a),
    .rd_b_tag (tag_b),
    .rd_d_tag (tag_d),
    .wr_en    (take_tag),
    .wr_idx   (in_dst),
    .wr_tag   (head_tag)
  );

  fpr_free_fifo #(.DEPTH(POOL_N), .TAG_W(TAG_W), .BASE(NUM_LOG)) i_pool (
    .clk       (clk),
    .rst       (rst),
    .pop       (take_tag),
    .push      (rel_valid),
    .push_tag  (rel_tag),
    .head_tag  (head_tag),
    .empty     (pool_empty),
    .err_over  (err_overflow),
    .err_under (err_underflow)
  );

  fpr_out_stage #(.TAG_W(TAG_W)) i_out (
    .clk         (clk),
    .rst         (rst),
    .take        (accept),
    .src_a_tag   (tag_a),
    .src_b_tag   (tag_b),
    .dst_tag     (dst_sel),
    .prev_tag    (tag_d),
    .alloc       (take_tag),
    .q_valid     (out_valid),
    .q_src_a_tag (out_src_a_tag),
    .q_src_b_tag (out_src_b_tag),
    .q_dst_tag   (out_dst_tag),
    .q_prev_tag  (out_prev_tag),
    .q_alloc     (out_alloc)
  );

endmodule

// File: rtl/fp_rename_map_chk.sv
module fp_rename_map_chk #(
  parameter int NUM_PHYS = 40,
  parameter int TAG_W    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_is_load,
  input logic             out_valid,
  input logic             out_alloc,
  input logic [TAG_W-1:0] out_dst_tag,
  input logic [TAG_W-1:0] out_prev_tag,
  input logic             err_underflow
);

  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R10
  stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !out_valid);

  // R6
  stall_only_load_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> in_is_load);

  // R3
  fresh_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_alloc) |-> (out_dst_tag != out_prev_tag));

  // R4
  arith_no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_is_load) |=> !out_alloc);

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    !err_underflow);

  // R3
  tag_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_dst_tag) < NUM_PHYS));

endmodule

bind fp_rename_map fp_rename_map_chk #(.NUM_PHYS(NUM_PHYS), .TAG_W(TAG_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_is_load    (in_is_load),
  .out_valid     (out_valid),
  .out_alloc     (out_alloc),
  .out_dst_tag   (out_dst_tag),
  .out_prev_tag  (out_prev_tag),
  .err_underflow (err_underflow)
);

// File: tb/test_fp_rename_map.sv
module test_fp_rename_map;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_is_load = 1'b0, in_wr_dst = 1'b0;
  logic [4:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic       rel_valid = 1'b0;
  logic [5:0] rel_tag = '0;
  logic       in_ready, out_valid, out_alloc, err_overflow, err_underflow;
  logic [5:0] out_src_a_tag, out_src_b_tag, out_dst_tag, out_prev_tag;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  fp_rename_map i_fp_rename_map (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_load(in_is_load), .in_wr_dst(in_wr_dst), .in_dst(in_dst),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .rel_valid(rel_valid),
    .rel_tag(rel_tag), .out_valid(out_valid), .out_src_a_tag(out_src_a_tag),
    .out_src_b_tag(out_src_b_tag), .out_dst_tag(out_dst_tag),
    .out_prev_tag(out_prev_tag), .out_alloc(out_alloc),
    .err_overflow(err_overflow), .err_underflow(err_underflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; rel_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Presents one instruction at a negedge, lets it be clocked, returns at the next negedge.
  task automatic issue(input logic ld, input logic wr, input int d, input int a, input int b);
    in_valid = 1'b1; in_is_load = ld; in_wr_dst = wr;
    in_dst = 5'(d); in_src_a = 5'(a); in_src_b = 5'(b);
    @(negedge clk);
    in_valid = 1'b0; in_is_load = 1'b0; in_wr_dst = 1'b0;
  endtask

  task automatic t_reset_identity();
    do_reset();
    chk("R10 out_valid after reset", int'(out_valid), 0);
    chk("R9 err_overflow after reset", int'(err_overflow), 0);
    for (int i = 0; i < 32; i += 2) begin
      issue(1'b0, 1'b0, 0, i, i + 1);
      chk("R1 src_a identity", int'(out_src_a_tag), i);
      chk("R1 src_b identity", int'(out_src_b_tag), i + 1);
      chk("R10 out_valid", int'(out_valid), 1);
    end
    issue(1'b0, 1'b1, 7, 5, 31);
    chk("R4 arith dst tag", int'(out_dst_tag), 7);
    chk("R4 arith prev tag", int'(out_prev_tag), 7);
    chk("R4 arith no alloc", int'(out_alloc), 0);
    @(negedge clk);
    chk("R10 valid drops", int'(out_valid), 0);
  endtask

  task automatic t_load_alloc();
    do_reset();
    issue(1'b1, 1'b0, 3, 3, 9);
    chk("R5 same-reg source old tag", int'(out_src_a_tag), 3);
    chk("R3 load new tag", int'(out_dst_tag), 32);
    chk("R3 load prev tag", int'(out_prev_tag), 3);
    chk("R3 load alloc", int'(out_alloc), 1);
    issue(1'b0, 1'b0, 0, 3, 2);
    chk("R3 lookup after load", int'(out_src_a_tag), 32);
    issue(1'b0, 1'b1, 3, 1, 1);
    chk("R11 arith writes remapped tag", int'(out_dst_tag), 32);
    chk("R11 no alloc", int'(out_alloc), 0);
    for (int k = 0; k < 7; k++) begin
      issue(1'b1, 1'b0, 10 + k, 0, 0);
      chk("R2 pool order", int'(out_dst_tag), 33 + k);
    end
  endtask

  task automatic t_stall_and_release();
    // continues from t_load_alloc: pool now empty
    in_valid = 1'b1; in_is_load = 1'b1; in_dst = 5'd20;
    #1;
    chk("R6 ready low on empty load", int'(in_ready), 0);
    @(negedge clk);
    chk("R6 stalled load no output", int'(out_valid), 0);
    in_valid = 1'b0; in_is_load = 1'b0;
    issue(1'b0, 1'b1, 12, 12, 4);
    chk("R6 non-load passes", int'(out_valid), 1);
    chk("R6 non-load tag", int'(out_dst_tag), 35);
    rel_valid = 1'b1; rel_tag = 6'd3;
    @(negedge clk);
    rel_tag = 6'd10;
    @(negedge clk);
    rel_valid = 1'b0;
    issue(1'b1, 1'b0, 20, 0, 0);
    chk("R7 first released tag", int'(out_dst_tag), 3);
    issue(1'b1, 1'b0, 21, 0, 0);
    chk("R7 second released tag", int'(out_dst_tag), 10);
  endtask

  task automatic t_same_cycle();
    do_reset();
    for (int k = 0; k < 8; k++) issue(1'b1, 1'b0, k, 0, 0);
    in_valid = 1'b1; in_is_load = 1'b1; in_dst = 5'd9;
    rel_valid = 1'b1; rel_tag = 6'd4;
    #1;
    chk("R8 release not usable same cycle", int'(in_ready), 0);
    @(negedge clk);
    rel_valid = 1'b0;
    chk("R8 no output in release cycle", int'(out_valid), 0);
    chk("R8 ready next cycle", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0; in_is_load = 1'b0;
    chk("R8 load accepted next cycle", int'(out_valid), 1);
    chk("R8 gets released tag", int'(out_dst_tag), 4);
  endtask

  task automatic t_overflow();
    do_reset();
    rel_valid = 1'b1; rel_tag = 6'd5;
    @(negedge clk);
    rel_valid = 1'b0;
    chk("R9 overflow pulse", int'(err_overflow), 1);
    @(negedge clk);
    chk("R9 overflow one cycle", int'(err_overflow), 0);
    for (int k = 0; k < 8; k++) begin
      issue(1'b1, 1'b0, 20 + k, 0, 0);
      chk("R9 pool unchanged", int'(out_dst_tag), 32 + k);
    end
    in_is_load = 1'b1;
    #1;
    chk("R9 dropped tag absent", int'(in_ready), 0);
    in_is_load = 1'b0;
    chk("R10 no underflow", int'(err_underflow), 0);
  endtask

  initial begin
    t_reset_identity();
    t_load_alloc();
    t_stall_and_release();
    t_same_cycle();
    t_overflow();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule